// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by reading page-table entries from memory, one level at a time. A one-cycle start pulse hands it the address, the paging mode and the table root. The walker then issues a single read per level on a plain request/response port. It stops at the first entry that ends the walk, whether that is a leaf page or a large page, or at the first entry whose present bit is clear. It reports the result with a one-cycle done or fault pulse and holds the physical address until the next start.

Three formats are handled. The 32-bit format has two levels and 4-byte entries. The three-level extended format starts from a four-entry top table. Long mode has four levels, or five when the five-level input is set. Long-mode addresses go through a sign-extension check before any read is made. An address-line-20 style mask is ANDed onto every entry fetch address. The block looks only at the present bit (bit 0) and the page-size bit (bit 7) of each entry. It has no permission logic, no accessed/dirty updates and no caching.

Top module: `pgwalk_top`

## Requirements
- R1: With `pagingOn` low at start, no memory read is made; `done` pulses on the first clock edge after the start edge, and `physAddr` equals `vaddr` ANDed with `a20Mask`.
- R2: In long mode (`longOn` high) the walk faults with no memory read unless `vaddr[63:47]` (or `vaddr[63:56]` when `fiveLvl` is high) is all zeros or all ones.
- R3: A four-level long-mode walk takes the first table base from `tableRoot` with bits 11:0 cleared. Each level's entry address is the base plus 8 times a 9-bit index taken from `vaddr` starting at bit 39, 30, 21 and then 12. The next base is the entry's bits 51:12. Entry bits 63:52 are ignored.
- R4: With `fiveLvl` high, an extra first level is read at `tableRoot` with bits 11:0 cleared, plus 8 times `vaddr[56:48]`, for five reads in a full walk.
- R5: In long mode a set page-size bit (bit 7) in the entry indexed by `vaddr[38:30]` ends the walk with a 1 GiB page. In long or extended mode a set bit 7 in the entry indexed by `vaddr[29:21]` ends it with a 2 MiB page.
- R6: In extended mode (`paeOn` high, `longOn` low) the first read is at `tableRoot` with bits 4:0 cleared, plus 8 times `vaddr[31:30]`. Bit 7 of that entry is ignored, and a full walk takes three reads.
- R7: In 32-bit mode (`paeOn` and `longOn` low) entries are 4 bytes and only `memRespData[31:0]` is used. The directory address is `tableRoot` bits 31:12 plus 4 times `vaddr[31:22]`, and the table address is the entry's bits 31:12 plus 4 times `vaddr[21:12]`.
- R8: In 32-bit mode a directory entry ends the walk with a 4 MiB page only if its bit 7 and `pseOn` are both high. Entry bits 20:13 then become physical bits 39:32. With `pseOn` low the entry is used as a table pointer.
- R9: An entry with bit 0 clear ends the walk at once. `fault` pulses, `done` stays low, `physAddr` reads zero, and no further read is made.
- R10: Every fetch address is ANDed with `a20Mask`. In 32-bit mode the final leaf entry is also masked.
- R11: Only one read is outstanding at a time. `busy` is high from the cycle after the start edge until `done` or `fault`. A start pulse while `busy` is high has no effect.
- R12: On success `physAddr` is the leaf entry's frame with the page-offset bits cleared, ORed with the `vaddr` bits below the page size (12, 21, 22 or 30 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to translate `vaddr` |
| vaddr | input | VA_W | Virtual address |
| pagingOn | input | 1 | Paging enabled |
| paeOn | input | 1 | Extended (64-bit entry) format |
| longOn | input | 1 | Long mode |
| fiveLvl | input | 1 | Five-level long mode |
| pseOn | input | 1 | Allow 4 MiB pages in 32-bit mode |
| tableRoot | input | PA_W | Root table pointer |
| a20Mask | input | PA_W | Mask ANDed onto fetch addresses |
| memReqValid | output | 1 | One-cycle read request |
| memReqAddr | output | PA_W | Read address |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | ENT_W | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle fault pulse |
| physAddr | output | PA_W | Translated address |

## Verification
The bench builds small page tables in a sparse memory model and goes after the early exits. These are the 1 GiB, 2 MiB and 4 MiB leaves. A design that missed one of them would make an extra read and return the wrong frame. The bench also sets page-size bits where they must be ignored: at the extended-mode top level and in 32-bit mode with `pseOn` low. A design that honoured them would end the walk too early. The canonical check is tested at both the 47-bit and the 56-bit boundary, on both the upper and the lower half, which catches a sign check on the wrong bit. Three further checks cover the rest. Garbage is placed in the upper response word in 32-bit mode. A mask is applied to address bit 20, which catches a fetch path that skips the mask. A start pulse is given in the middle of a walk, and it must not disturb the result.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;       // capture request, set up first level
    logic flatDone;   // paging off: result is masked address
    logic earlyFault; // rejected before any read
    logic descend;    // entry points to next table
    logic leafDone;   // entry ends the walk
    logic walkFault;  // entry not present
  } pw_strobe_t;

  // conditions from the datapath back to the sequencer
  typedef struct packed {
    logic isFlat;
    logic nonCanon;
    logic present;
    logic leaf;
  } pw_status_t;

  typedef struct packed {
    logic longMode;
    logic fiveLvl;
    logic leg32;
    logic pse;
  } pw_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } pw_state_e;

endpackage

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
#(
  parameter int VA_W  = 64,   // must be at least 57
  parameter int PA_W  = 52,
  parameter int ENT_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              pagingOn,
  input  logic              paeOn,
  input  logic              longOn,
  input  logic              fiveLvl,
  input  logic              pseOn,
  input  logic [PA_W-1:0]   tableRoot,
  input  logic [PA_W-1:0]   a20Mask,
  input  logic [ENT_W-1:0]  memRespData,
  input  pw_strobe_t        strobe,
  output pw_status_t        status,
  output logic [PA_W-1:0]   memReqAddr,
  output logic [PA_W-1:0]   physAddr
);

  localparam int LVL_W   = 3;
  localparam int SH_W    = 6;
  localparam int IDX_W   = 10;
  localparam int VA_KEEP = 57;  // highest index bit is 56
  localparam logic [PA_W-1:0] PAGE_CLR = ~PA_W'(12'hFFF);
  localparam logic [PA_W-1:0] TOP_CLR  = ~PA_W'(5'h1F);

  pw_mode_t               modeIn, modeR;
  logic [VA_KEEP-1:0]     vaR;
  logic [LVL_W-1:0]       levelR, startLvl;
  logic [PA_W-1:0]        baseR, startBase, paR;

  // ---------------- request-side decode ----------------
  logic [VA_W-48:0] hiFour;
  logic [VA_W-57:0] hiFive;
  logic             canonFour, canonFive;

  always_comb begin
    modeIn.longMode = longOn;
    modeIn.fiveLvl  = longOn & fiveLvl;
    modeIn.leg32    = ~longOn & ~paeOn;
    modeIn.pse      = pseOn;

    hiFour    = vaddr[VA_W-1:47];
    hiFive    = vaddr[VA_W-1:56];
    canonFour = (&hiFour) | ~(|hiFour);
    canonFive = (&hiFive) | ~(|hiFive);

    status.isFlat   = ~pagingOn;
    status.nonCanon = longOn & (fiveLvl ? ~canonFive : ~canonFour);

    if (longOn) begin
      startLvl  = fiveLvl ? LVL_W'(4) : LVL_W'(3);
      startBase = tableRoot & PAGE_CLR;
    end else if (paeOn) begin
      startLvl  = LVL_W'(2);
      startBase = tableRoot & TOP_CLR;
    end else begin
      startLvl  = LVL_W'(1);
      startBase = PA_W'(tableRoot[31:0]) & PAGE_CLR;
    end
  end

  // ---------------- fetch address ----------------
  logic [SH_W-1:0]  idxSh;
  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  idxOffs;
  logic             paeTop;

  always_comb begin
    paeTop = ~modeR.leg32 & ~modeR.longMode & (levelR == LVL_W'(2));
    if (modeR.leg32) begin
      idxSh   = SH_W'(12) + SH_W'(10) * SH_W'(levelR);
      idx     = IDX_W'(vaR >> idxSh) & IDX_W'(10'h3FF);
      idxOffs = PA_W'(idx) << 2;
    end else begin
      idxSh   = SH_W'(12) + SH_W'(9) * SH_W'(levelR);
      idx     = IDX_W'(vaR >> idxSh) & (paeTop ? IDX_W'(3) : IDX_W'(9'h1FF));
      idxOffs = PA_W'(idx) << 3;
    end
    memReqAddr = (baseR + idxOffs) & a20Mask;
  end

  // ---------------- entry evaluation ----------------
  logic [ENT_W-1:0] ent, entWide;
  logic             psBit, sizeStop;
  logic [SH_W-1:0]  pageSh;
  logic [PA_W-1:0]  pteP, lowMask, leafPa, nextBase;

  always_comb begin
    ent   = modeR.leg32 ? ENT_W'(memRespData[31:0]) : memRespData;
    psBit = ent[7];

    if (modeR.leg32)
      sizeStop = psBit & modeR.pse & (levelR == LVL_W'(1));
    else
      sizeStop = psBit & ((levelR == LVL_W'(1)) |
                          (modeR.longMode & (levelR == LVL_W'(2))));

    status.present = ent[0];
    status.leaf    = (levelR == '0) | sizeStop;

    if (modeR.leg32)
      pageSh = (levelR == LVL_W'(1)) ? SH_W'(22) : SH_W'(12);
    else
      pageSh = SH_W'(12) + SH_W'(9) * SH_W'(levelR);

    // large 32-bit page: entry bits 20:13 extend the frame above bit 31
    if (modeR.leg32 && levelR == LVL_W'(1))
      entWide = ent | (ENT_W'(ent[20:13]) << 32);
    else
      entWide = ent;

    pteP     = PA_W'(entWide) & (modeR.leg32 ? a20Mask : '1);
    lowMask  = (PA_W'(1) << pageSh) - PA_W'(1);
    leafPa   = (pteP & ~lowMask) | (PA_W'(vaR) & lowMask);
    nextBase = PA_W'(ent) & PAGE_CLR;
  end

  // ---------------- state ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR  <= '0;
      vaR    <= '0;
      levelR <= '0;
      baseR  <= '0;
      paR    <= '0;
    end else begin
      if (strobe.load) begin
        modeR  <= modeIn;
        vaR    <= vaddr[VA_KEEP-1:0];
        levelR <= startLvl;
        baseR  <= startBase;
      end
      if (strobe.descend) begin
        baseR  <= nextBase;
        levelR <= levelR - LVL_W'(1);
      end
      if (strobe.flatDone)
        paR <= PA_W'(vaddr) & a20Mask;
      else if (strobe.leafDone)
        paR <= leafPa;
      else if (strobe.earlyFault || strobe.walkFault)
        paR <= '0;
    end
  end

  assign physAddr = paR;

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memRespValid,
  input  pw_status_t status,
  output pw_strobe_t strobe,
  output logic       memReqValid,
  output logic       busy,
  output logic       done,
  output logic       fault
);

  pw_state_e state, stateNxt;
  logic      doneR, faultR;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (status.isFlat)        strobe.flatDone   = 1'b1;
          else if (status.nonCanon) strobe.earlyFault = 1'b1;
          else begin
            strobe.load = 1'b1;
            stateNxt    = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: stateNxt = ST_WAIT;
      ST_WAIT: begin
        if (memRespValid) begin
          if (!status.present) begin
            strobe.walkFault = 1'b1;
            stateNxt         = ST_IDLE;
          end else if (status.leaf) begin
            strobe.leafDone = 1'b1;
            stateNxt        = ST_IDLE;
          end else begin
            strobe.descend = 1'b1;
            stateNxt       = ST_ISSUE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      doneR  <= 1'b0;
      faultR <= 1'b0;
    end else begin
      state  <= stateNxt;
      doneR  <= strobe.flatDone | strobe.leafDone;
      faultR <= strobe.earlyFault | strobe.walkFault;
    end
  end

  assign memReqValid = (state == ST_ISSUE);
  assign busy        = (state != ST_IDLE);
  assign done        = doneR;
  assign fault       = faultR;

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int PA_W  = 52,
  parameter int ENT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             pagingOn,
  input  logic             paeOn,
  input  logic             longOn,
  input  logic             fiveLvl,
  input  logic             pseOn,
  input  logic [PA_W-1:0]  tableRoot,
  input  logic [PA_W-1:0]  a20Mask,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRespValid,
  input  logic [ENT_W-1:0] memRespData,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  physAddr
);

  pw_strobe_t strobe;
  pw_status_t status;

  pgwalk_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .memRespValid (memRespValid),
    .status       (status),
    .strobe       (strobe),
    .memReqValid  (memReqValid),
    .busy         (busy),
    .done         (done),
    .fault        (fault)
  );

  pgwalk_dp #(.VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .vaddr       (vaddr),
    .pagingOn    (pagingOn),
    .paeOn       (paeOn),
    .longOn      (longOn),
    .fiveLvl     (fiveLvl),
    .pseOn       (pseOn),
    .tableRoot   (tableRoot),
    .a20Mask     (a20Mask),
    .memRespData (memRespData),
    .strobe      (strobe),
    .status      (status),
    .memReqAddr  (memReqAddr),
    .physAddr    (physAddr)
  );

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int VA_W = 64,
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [VA_W-1:0] vaddr,
  input logic            pagingOn,
  input logic            longOn,
  input logic            fiveLvl,
  input logic [PA_W-1:0] a20Mask,
  input logic            memReqValid,
  input logic [PA_W-1:0] memReqAddr,
  input logic            memRespValid,
  input logic            busy,
  input logic            done,
  input logic            fault,
  input logic [PA_W-1:0] physAddr
);

  logic outstanding;
  logic badAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outstanding <= 1'b0;
    else if (memReqValid) outstanding <= 1'b1;
    else if (memRespValid) outstanding <= 1'b0;
  end

  always_comb begin
    if (fiveLvl)
      badAddr = !((&vaddr[VA_W-1:56]) || !(|vaddr[VA_W-1:56]));
    else
      badAddr = !((&vaddr[VA_W-1:47]) || !(|vaddr[VA_W-1:47]));
  end

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstanding);

  assert_req_while_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

  assert_end_reported_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || fault));

  assert_idle_at_result_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done || fault) |-> !busy);

  assert_fetch_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> ((memReqAddr & ~a20Mask) == '0));

  assert_fault_clean_R9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!done && physAddr == '0));

  assert_flat_result_R1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !pagingOn) |=>
      (done && physAddr == ($past(vaddr[PA_W-1:0]) & $past(a20Mask))));

  assert_canon_reject_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && pagingOn && longOn && badAddr) |=> (fault && !busy && !memReqValid));

endmodule

bind pgwalk_top pgwalk_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .vaddr        (vaddr),
  .pagingOn     (pagingOn),
  .longOn       (longOn),
  .fiveLvl      (fiveLvl),
  .a20Mask      (a20Mask),
  .memReqValid  (memReqValid),
  .memReqAddr   (memReqAddr),
  .memRespValid (memRespValid),
  .busy         (busy),
  .done         (done),
  .fault        (fault),
  .physAddr     (physAddr)
);

// File: tb/pgwalk_top_bench.sv
`timescale 1ns/1ps
module pgwalk_top_bench;

  localparam int VA_W  = 64;
  localparam int PA_W  = 52;
  localparam int ENT_W = 64;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [VA_W-1:0]  vaddr = '0;
  logic             pagingOn = 1'b0, paeOn = 1'b0, longOn = 1'b0, fiveLvl = 1'b0, pseOn = 1'b0;
  logic [PA_W-1:0]  tableRoot = '0;
  logic [PA_W-1:0]  a20Mask = '1;
  logic             memReqValid;
  logic [PA_W-1:0]  memReqAddr;
  logic             memRespValid = 1'b0;
  logic [ENT_W-1:0] memRespData = '0;
  logic             busy, done, fault;
  logic [PA_W-1:0]  physAddr;

  always #2 clk = ~clk;

  pgwalk_top #(.VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W)) u_pgwalk_top (
    .clk(clk), .rstN(rstN), .start(start), .vaddr(vaddr),
    .pagingOn(pagingOn), .paeOn(paeOn), .longOn(longOn), .fiveLvl(fiveLvl),
    .pseOn(pseOn), .tableRoot(tableRoot), .a20Mask(a20Mask),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .busy(busy), .done(done), .fault(fault), .physAddr(physAddr)
  );

  // ---------------- sparse memory model, one-cycle latency ----------------
  logic [63:0] mem [longint unsigned];
  logic        pend = 1'b0;
  logic [63:0] pendAddr = '0;
  int          reqCount = 0;
  logic [63:0] reqLog [0:255];

  always @(posedge clk) begin
    memRespValid <= 1'b0;
    if (pend) begin
      memRespValid <= 1'b1;
      memRespData  <= mem.exists(pendAddr) ? mem[pendAddr] : 64'h0;
      pend         <= 1'b0;
    end
    if (memReqValid) begin
      pend     <= 1'b1;
      pendAddr <= 64'(memReqAddr);
      reqLog[reqCount[7:0]] <= 64'(memReqAddr);
      reqCount <= reqCount + 1;
    end
  end

  // ---------------- bookkeeping ----------------
  int checks = 0;
  int failures = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [PA_W-1:0] resPa;
  logic            resFault, resDone, resBusy;
  int              resReads, resCycles, logBase;

  task automatic walk(input logic [63:0] va, input logic pg, input logic pae,
                      input logic lm, input logic five, input logic pse,
                      input logic [PA_W-1:0] root, input logic inject);
    int cyc;
    @(negedge clk);
    vaddr = va; pagingOn = pg; paeOn = pae; longOn = lm; fiveLvl = five;
    pseOn = pse; tableRoot = root;
    logBase = reqCount;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    resBusy = busy;
    cyc = 1;
    while (!(done || fault) && cyc < 200) begin
      if (inject && cyc == 2) begin start = 1'b1; pagingOn = 1'b0; vaddr = ~va; end
      @(negedge clk);
      cyc++;
      if (inject && cyc == 3) begin start = 1'b0; pagingOn = pg; vaddr = va; end
    end
    if (cyc >= 200) check("R11 walk timeout", 64'(cyc), 64'(0));
    resCycles = cyc;
    resPa     = physAddr;
    resFault  = fault;
    resDone   = done;
    resReads  = reqCount - logBase;
    @(negedge clk);
  endtask

  function automatic logic [63:0] firstRead();
    return reqLog[logBase[7:0]];
  endfunction

  function automatic logic [63:0] nthRead(input int n);
    return reqLog[8'(logBase + n)];
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R11 reset busy", 64'(busy), 64'(0));
    check("R11 reset done", 64'(done), 64'(0));
    check("R9 reset fault", 64'(fault), 64'(0));
    check("R11 reset memReqValid", 64'(memReqValid), 64'(0));
  endtask

  task automatic t_flat();
    mem.delete();
    a20Mask = '1;
    walk(64'h0000_0ABC_1234_5678, 0, 0, 0, 0, 0, '0, 0);
    check("R1 flat pa", 64'(resPa), 64'h0ABC_1234_5678);
    check("R1 flat latency", 64'(resCycles), 64'(1));
    check("R1 flat no reads", 64'(resReads), 64'(0));
    check("R1 flat done", 64'(resDone), 64'(1));
  endtask

  task automatic t_long4();
    logic [8:0] i4, i3, i2, i1;
    logic [63:0] va;
    mem.delete();
    i4 = 9'h0A5; i3 = 9'h13C; i2 = 9'h007; i1 = 9'h1FF;
    va = {16'h0, i4, i3, i2, i1, 12'hABC};
    mem[64'h1000 + 64'(i4) * 8] = 64'h8000_0000_0000_2001;
    mem[64'h2000 + 64'(i3) * 8] = 64'h0000_0000_0000_3001;
    mem[64'h3000 + 64'(i2) * 8] = 64'hFFF0_0000_0000_4001;
    mem[64'h4000 + 64'(i1) * 8] = 64'h8000_000A_BCDE_F063;
    walk(va, 1, 1, 1, 0, 0, 52'h1234, 0);
    check("R3 long4 pa", 64'(resPa), 64'h000A_BCDE_FABC);
    check("R3 long4 reads", 64'(resReads), 64'(4));
    check("R3 long4 first addr", firstRead(), 64'h1000 + 64'(i4) * 8);
    check("R3 long4 last addr", nthRead(3), 64'h4000 + 64'(i1) * 8);
    check("R11 busy after start", 64'(resBusy), 64'(1));
    check("R12 long4 no fault", 64'(resFault), 64'(0));
  endtask

  task automatic t_five();
    logic [8:0] i5, i4, i3, i2, i1;
    logic [63:0] va;
    mem.delete();
    i5 = 9'h0C3; i4 = 9'h011; i3 = 9'h022; i2 = 9'h033; i1 = 9'h044;
    va = {7'h0, i5, i4, i3, i2, i1, 12'h0F0};
    mem[64'h10_0000 + 64'(i5) * 8] = 64'h11001;
    mem[64'h11000 + 64'(i4) * 8]   = 64'h12001;
    mem[64'h12000 + 64'(i3) * 8]   = 64'h13001;
    mem[64'h13000 + 64'(i2) * 8]   = 64'h14001;
    mem[64'h14000 + 64'(i1) * 8]   = 64'h5_5555_5001;
    walk(va, 1, 1, 1, 1, 0, 52'h10_00AB, 0);
    check("R4 five pa", 64'(resPa), 64'h5_5555_50F0);
    check("R4 five reads", 64'(resReads), 64'(5));
    check("R4 five first addr", firstRead(), 64'h10_0000 + 64'(i5) * 8);
  endtask

  task automatic t_canon();
    logic [8:0] i4, i3;
    logic [63:0] va;
    mem.delete();
    // lower-half address with bit 47 set: rejected in four-level mode
    walk(64'h0000_8000_0000_0000, 1, 1, 1, 0, 0, 52'h1000, 0);
    check("R2 noncanon4 fault", 64'(resFault), 64'(1));
    check("R2 noncanon4 reads", 64'(resReads), 64'(0));
    check("R9 noncanon4 pa", 64'(resPa), 64'(0));
    // same address is legal with five levels; empty table faults after one read
    walk(64'h0000_8000_0000_0000, 1, 1, 1, 1, 0, 52'h1000, 0);
    check("R2 five accepts bit47", 64'(resReads), 64'(1));
    check("R9 empty top fault", 64'(resFault), 64'(1));
    // bit 56 alone breaks the five-level rule
    walk(64'h0100_0000_0000_0000, 1, 1, 1, 1, 0, 52'h1000, 0);
    check("R2 noncanon5 fault", 64'(resFault), 64'(1));
    check("R2 noncanon5 reads", 64'(resReads), 64'(0));
    // upper-half address, 1 GiB page
    i4 = 9'h180; i3 = 9'h05A;
    va = {16'hFFFF, i4, i3, 30'h0123_4567};
    mem[64'h1000 + 64'(i4) * 8] = 64'h2001;
    mem[64'h2000 + 64'(i3) * 8] = 64'h7_4000_0081;
    walk(va, 1, 1, 1, 0, 0, 52'h1000, 0);
    check("R5 1G pa", 64'(resPa), 64'h7_4000_0000 | 64'h0123_4567);
    check("R5 1G reads", 64'(resReads), 64'(2));
    check("R2 upper half accepted", 64'(resFault), 64'(0));
  endtask

  task automatic t_large2m();
    logic [8:0] i4, i3, i2;
    logic [63:0] va;
    mem.delete();
    i4 = 9'h001; i3 = 9'h002; i2 = 9'h003;
    va = {16'h0, i4, i3, i2, 21'h1F_ABCD};
    mem[64'h1000 + 64'(i4) * 8] = 64'h2001;
    mem[64'h2000 + 64'(i3) * 8] = 64'h3001;
    mem[64'h3000 + 64'(i2) * 8] = 64'h0060_0081;
    walk(va, 1, 1, 1, 0, 0, 52'h1000, 0);
    check("R5 2M pa", 64'(resPa), 64'h0060_0000 | 64'h1F_ABCD);
    check("R5 2M reads", 64'(resReads), 64'(3));
  endtask

  task automatic t_pae();
    logic [63:0] va, dAddr, tAddr;
    mem.delete();
    va = 64'h0000_0000_8123_4567;
    mem[64'h5030] = 64'h6081;  // page-size bit must be ignored here
    dAddr = 64'h6000 + ((va >> 21) & 64'h1FF) * 8;
    mem[dAddr] = 64'h7001;
    tAddr = 64'h7000 + ((va >> 12) & 64'h1FF) * 8;
    mem[tAddr] = 64'h1234_5001;
    walk(va, 1, 1, 0, 0, 0, 52'h5027, 0);
    check("R6 pae first addr", firstRead(), 64'h5030);
    check("R6 pae reads", 64'(resReads), 64'(3));
    check("R6 pae pa", 64'(resPa), 64'h1234_5567);
  endtask

  task automatic t_leg32();
    mem.delete();
    // directory index 0x201, table index 0x003
    mem[64'h7804] = 64'hDEAD_BEEF_0000_9001;
    mem[64'h900C] = 64'hFFFF_FFFF_A000_0001;
    walk(64'h0000_0000_8040_3ABC, 1, 0, 0, 0, 0, 52'h7123, 0);
    check("R7 leg32 first addr", firstRead(), 64'h7804);
    check("R7 leg32 second addr", nthRead(1), 64'h900C);
    check("R7 leg32 pa", 64'(resPa), 64'hA000_0ABC);
  endtask

  task automatic t_pse();
    logic [63:0] pde, tAddr;
    mem.delete();
    pde = 64'h0040_0000 | (64'h5A << 13) | 64'h81;
    mem[64'h7000 + 64'h201 * 4] = pde;
    walk(64'h0000_0000_8052_3ABC, 1, 0, 0, 0, 1, 52'h7000, 0);
    check("R8 4M pa", 64'(resPa), (64'h5A << 32) | 64'h0040_0000 | 64'h0012_3ABC);
    check("R8 4M reads", 64'(resReads), 64'(1));
    // same entry without large pages is a table pointer
    tAddr = (pde & 64'hFFFF_F000) + 64'h123 * 4;
    mem[tAddr] = 64'h00AB_C001;
    walk(64'h0000_0000_8052_3ABC, 1, 0, 0, 0, 0, 52'h7000, 0);
    check("R8 pse off reads", 64'(resReads), 64'(2));
    check("R8 pse off second addr", nthRead(1), tAddr);
    check("R12 pse off pa", 64'(resPa), 64'h00AB_CABC);
  endtask

  task automatic t_absent();
    logic [8:0] i4, i3;
    mem.delete();
    i4 = 9'h003; i3 = 9'h004;
    mem[64'h1000 + 64'(i4) * 8] = 64'h2001;
    mem[64'h2000 + 64'(i3) * 8] = 64'h3000;  // present bit clear
    walk({16'h0, i4, i3, 30'h0}, 1, 1, 1, 0, 0, 52'h1000, 0);
    check("R9 absent fault", 64'(resFault), 64'(1));
    check("R9 absent reads", 64'(resReads), 64'(2));
    check("R9 absent pa", 64'(resPa), 64'(0));
    check("R9 absent no done", 64'(resDone), 64'(0));
  endtask

  task automatic t_a20();
    mem.delete();
    @(negedge clk);
    a20Mask = ~(52'h1 << 20);
    walk(64'h0000_0000_1234_5678, 0, 0, 0, 0, 0, '0, 0);
    check("R10 flat mask", 64'(resPa), 64'h1224_5678);
    mem[64'h7000] = 64'h0010_9001;
    mem[64'h9000] = 64'h001F_F001;
    walk(64'h0000_0000_0000_0ABC, 1, 0, 0, 0, 0, 52'h10_7000, 0);
    check("R10 masked dir fetch", firstRead(), 64'h7000);
    check("R10 masked table fetch", nthRead(1), 64'h9000);
    check("R10 masked leaf", 64'(resPa), 64'h000F_FABC);
    @(negedge clk);
    a20Mask = '1;
  endtask

  task automatic t_ignore();
    mem.delete();
    mem[64'h7804] = 64'h9001;
    mem[64'h900C] = 64'h00C0_0001;
    walk(64'h0000_0000_8040_3ABC, 1, 0, 0, 0, 0, 52'h7000, 1);
    check("R11 start ignored pa", 64'(resPa), 64'h00C0_0ABC);
    check("R11 start ignored reads", 64'(resReads), 64'(2));
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_flat();
    t_long4();
    t_five();
    t_canon();
    t_large2m();
    t_pae();
    t_leg32();
    t_pse();
    t_absent();
    t_a20();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule